// File: doc/BRIEF.md
# Segmented Backplane Window Translator

This card-side block lets a host reach a 32-bit internal backplane through a small memory window. A byte-wide configuration port holds four registers. Three of them set the window base: one 4-bit register for address bits 15:12 and two 8-bit registers for bits 23:16 and 31:24. The fourth is a one-bit segment selector that picks the lower or upper 2 KB half of the selected 4 KB core slot. Software confirms every switch by reading the register back after writing it, so every register returns exactly the value it stores.

A host access carries a 12-bit window offset, a two-lane byte enable and, for a write, 16 bits of data. The block joins the stored base, the segment bit and the low eleven offset bits into a backplane address. It then raises one request on a valid/ready backplane port and holds the host ready signal low until the access is finished. A read waits for a backplane response. If that response reports an error, the read returns all ones. A 32-bit host transfer is made as two separate 16-bit accesses, to the offset and then to the offset plus two.

Top module: `bpwin_xlate`

## Requirements
- R1: After reset all four window registers read back 0x00, no backplane request is pending and the host ready signal is low.
- R2: The registers at configuration offsets 0x30 (address bits 23:16) and 0x32 (address bits 31:24) read back exactly the last byte written to them.
- R3: The register at configuration offset 0x2E stores only bits 3:0 of a written byte and reads back as {4'b0000, stored nibble}.
- R4: The register at configuration offset 0x34 stores only bit 0 of a written byte and reads back as {7'b0, stored bit}.
- R5: A write to any other configuration offset changes no register, and a read of any other offset returns 0x00.
- R6: The backplane address is {reg 0x32, reg 0x30, reg 0x2E nibble, segment bit, host offset[10:0]}. Host offset bit 11 has no effect on it.
- R7: Each host access raises bp_valid exactly once. bp_valid stays high with address, write flag, byte enables and write data unchanged until the cycle in which bp_ready is high.
- R8: hst_ready is low while a request is outstanding and is high for exactly one cycle when an access finishes. For a write this is the cycle after bp_ready is accepted. For a read it is the cycle after the response is accepted, which may come in the same cycle as bp_ready.
- R9: A read whose response has bp_rsp_err high returns 0xFFFF on hst_rdata. Otherwise the read returns bp_rsp_data.
- R10: A configuration write in the same cycle that a host access is accepted, or while that access waits for bp_ready, does not change that access's address. The next access uses the new value.
- R11: Byte enables pass to the backplane unchanged: 2'b11 for a 16-bit access, 2'b01 for the low byte and 2'b10 for the high byte. Write data also passes through unchanged.
- R12: A backplane response arriving while no read is waiting is ignored, and the next read returns its own response data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration register offset (read and write) |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Readback of the register at cfg_addr |
| hst_req | input | 1 | Host access request, held until hst_ready |
| hst_we | input | 1 | Host access is a write |
| hst_off | input | 12 | Host window offset |
| hst_be | input | 2 | Host byte lane enables |
| hst_wdata | input | 16 | Host write data |
| hst_ready | output | 1 | One-cycle access completion |
| hst_rdata | output | 16 | Read data, valid with hst_ready |
| bp_valid | output | 1 | Backplane request valid |
| bp_we | output | 1 | Backplane request is a write |
| bp_addr | output | 32 | Backplane byte address |
| bp_be | output | 2 | Backplane byte lane enables |
| bp_wdata | output | 16 | Backplane write data |
| bp_ready | input | 1 | Backplane accepts the request |
| bp_rsp_valid | input | 1 | Backplane read response valid |
| bp_rsp_err | input | 1 | Backplane read response error |
| bp_rsp_data | input | 16 | Backplane read response data |

## Verification
Two functions can fall in the same cycle. The first is a configuration write to a base or segment register while a host access is being launched or is stalled waiting for bp_ready. The bench drives the register write in the very cycle hst_req is taken, and again during a stall. It then expects the old address on the pending request and the new address on the next one. The second is a read response that arrives together with bp_ready. The bench drives both in one cycle and expects the completion one cycle later with the response data. A behavioural model of the register file is compared with cfg_rdata on every clock, and every backplane request and host completion is compared against addresses and data computed from that model.

// File: rtl/bpwin_pkg.sv
package bpwin_pkg;

    parameter int BP_AW   = 32;
    parameter int HOST_OW = 12;
    parameter int HOST_DW = 16;
    parameter int CFG_AW  = 8;
    parameter int CFG_DW  = 8;

    localparam int HOST_BW  = HOST_DW / 8;
    localparam int SEG_POS  = HOST_OW - 1;
    localparam int NIB_W    = 16 - HOST_OW;
    localparam int MID_W    = 8;
    localparam int HI_W     = BP_AW - 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } txn_st_e;

    typedef struct packed {
        logic [HI_W-1:0]  base_hi;
        logic [MID_W-1:0] base_mid;
        logic [NIB_W-1:0] base_nib;
        logic             seg;
    } win_regs_t;

    typedef struct packed {
        txn_st_e              st;
        logic                 we;
        logic [BP_AW-1:0]     addr;
        logic [HOST_BW-1:0]   be;
        logic [HOST_DW-1:0]   wdata;
        logic [HOST_DW-1:0]   rdata;
    } txn_t;

endpackage

// File: rtl/bpwin_cfg_regs.sv
module bpwin_cfg_regs
    import bpwin_pkg::*;
#(
    parameter logic [CFG_AW-1:0] OFF_NIB = 8'h2E,
    parameter logic [CFG_AW-1:0] OFF_MID = 8'h30,
    parameter logic [CFG_AW-1:0] OFF_HI  = 8'h32,
    parameter logic [CFG_AW-1:0] OFF_SEG = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output win_regs_t         regs_o
);

    win_regs_t regs_d, regs_q;

    // Next-state: only mapped offsets take a write, each keeping its own width.
    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            case (cfg_addr)
                OFF_NIB: regs_d.base_nib = cfg_wdata[NIB_W-1:0];
                OFF_MID: regs_d.base_mid = cfg_wdata[MID_W-1:0];
                OFF_HI:  regs_d.base_hi  = cfg_wdata[HI_W-1:0];
                OFF_SEG: regs_d.seg      = cfg_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Readback mux, zero-extended to the port width.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFF_NIB: cfg_rdata[NIB_W-1:0] = regs_q.base_nib;
            OFF_MID: cfg_rdata[MID_W-1:0] = regs_q.base_mid;
            OFF_HI:  cfg_rdata[HI_W-1:0]  = regs_q.base_hi;
            OFF_SEG: cfg_rdata[0]         = regs_q.seg;
            default: cfg_rdata = '0;
        endcase
    end

    assign regs_o = regs_q;

    // R3: the nibble register keeps the low four bits of the written byte.
    p_nib_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFF_NIB) |=> (regs_o.base_nib == $past(cfg_wdata[NIB_W-1:0])));

    // R4: the segment register keeps only bit 0.
    p_seg_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFF_SEG) |=> (regs_o.seg == $past(cfg_wdata[0])));

    // R5: no write strobe means no register moves.
    p_no_write_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(regs_o));

endmodule

// File: rtl/bpwin_addr_form.sv
module bpwin_addr_form
    import bpwin_pkg::*;
(
    input  win_regs_t          regs_i,
    input  logic [HOST_OW-1:0] off_i,
    output logic [BP_AW-1:0]   addr_o
);

    localparam int FORMED_W = HI_W + MID_W + NIB_W + 1 + SEG_POS;

    // Offset MSB is dropped; the stored segment bit takes its place.
    assign addr_o = {regs_i.base_hi, regs_i.base_mid, regs_i.base_nib,
                     regs_i.seg, off_i[SEG_POS-1:0]};

    initial begin
        a_width_r6: assert (FORMED_W == BP_AW);
    end

endmodule

// File: rtl/bpwin_txn_fsm.sv
module bpwin_txn_fsm
    import bpwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic [HOST_BW-1:0] hst_be,
    input  logic [HOST_DW-1:0] hst_wdata,
    input  logic [BP_AW-1:0]   xlate_addr,
    output logic               hst_ready,
    output logic [HOST_DW-1:0] hst_rdata,
    output logic               bp_valid,
    output logic               bp_we,
    output logic [BP_AW-1:0]   bp_addr,
    output logic [HOST_BW-1:0] bp_be,
    output logic [HOST_DW-1:0] bp_wdata,
    input  logic               bp_ready,
    input  logic               bp_rsp_valid,
    input  logic               bp_rsp_err,
    input  logic [HOST_DW-1:0] bp_rsp_data
);

    txn_t txn_d, txn_q;
    logic [HOST_DW-1:0] rsp_word;

    assign rsp_word = bp_rsp_err ? {HOST_DW{1'b1}} : bp_rsp_data;

    always_comb begin
        txn_d = txn_q;
        case (txn_q.st)
            ST_IDLE: begin
                if (hst_req) begin
                    txn_d.st    = ST_REQ;
                    txn_d.we    = hst_we;
                    txn_d.addr  = xlate_addr;
                    txn_d.be    = hst_be;
                    txn_d.wdata = hst_wdata;
                end
            end
            ST_REQ: begin
                if (bp_ready) begin
                    if (txn_q.we) begin
                        txn_d.st = ST_DONE;
                    end else if (bp_rsp_valid) begin
                        txn_d.st    = ST_DONE;
                        txn_d.rdata = rsp_word;
                    end else begin
                        txn_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (bp_rsp_valid) begin
                    txn_d.st    = ST_DONE;
                    txn_d.rdata = rsp_word;
                end
            end
            ST_DONE: txn_d.st = ST_IDLE;
            default: txn_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txn_q <= '0;
        else        txn_q <= txn_d;
    end

    assign bp_valid  = (txn_q.st == ST_REQ);
    assign bp_we     = txn_q.we;
    assign bp_addr   = txn_q.addr;
    assign bp_be     = txn_q.be;
    assign bp_wdata  = txn_q.wdata;
    assign hst_ready = (txn_q.st == ST_DONE);
    assign hst_rdata = txn_q.rdata;

    // R7: a stalled request keeps every field steady.
    p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_valid && !bp_ready) |=> (bp_valid && $stable(bp_addr) && $stable(bp_we)
                                     && $stable(bp_be) && $stable(bp_wdata)));

    // R8: completion lasts one cycle.
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ready |=> !hst_ready);

    // R8: never complete while the request is still on the backplane.
    p_ready_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bp_valid |-> !hst_ready);

    // R9: an error response turns into all ones at the host.
    p_err_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_q.st == ST_WAIT && bp_rsp_valid && bp_rsp_err)
            |=> (hst_ready && hst_rdata == {HOST_DW{1'b1}}));

    // R12: a response with no read waiting leaves the read data alone.
    p_stray_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_q.st == ST_IDLE && !hst_req) |=> $stable(hst_rdata));

endmodule

// File: rtl/bpwin_xlate.sv
module bpwin_xlate
    import bpwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    output logic [CFG_DW-1:0]   cfg_rdata,
    input  logic                hst_req,
    input  logic                hst_we,
    input  logic [HOST_OW-1:0]  hst_off,
    input  logic [HOST_BW-1:0]  hst_be,
    input  logic [HOST_DW-1:0]  hst_wdata,
    output logic                hst_ready,
    output logic [HOST_DW-1:0]  hst_rdata,
    output logic                bp_valid,
    output logic                bp_we,
    output logic [BP_AW-1:0]    bp_addr,
    output logic [HOST_BW-1:0]  bp_be,
    output logic [HOST_DW-1:0]  bp_wdata,
    input  logic                bp_ready,
    input  logic                bp_rsp_valid,
    input  logic                bp_rsp_err,
    input  logic [HOST_DW-1:0]  bp_rsp_data
);

    win_regs_t          win_regs;
    logic [BP_AW-1:0]   formed_addr;

    bpwin_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .regs_o    (win_regs)
    );

    bpwin_addr_form u_addr (
        .regs_i (win_regs),
        .off_i  (hst_off),
        .addr_o (formed_addr)
    );

    bpwin_txn_fsm u_txn (
        .clk          (clk),
        .rst_n        (rst_n),
        .hst_req      (hst_req),
        .hst_we       (hst_we),
        .hst_be       (hst_be),
        .hst_wdata    (hst_wdata),
        .xlate_addr   (formed_addr),
        .hst_ready    (hst_ready),
        .hst_rdata    (hst_rdata),
        .bp_valid     (bp_valid),
        .bp_we        (bp_we),
        .bp_addr      (bp_addr),
        .bp_be        (bp_be),
        .bp_wdata     (bp_wdata),
        .bp_ready     (bp_ready),
        .bp_rsp_valid (bp_rsp_valid),
        .bp_rsp_err   (bp_rsp_err),
        .bp_rsp_data  (bp_rsp_data)
    );

    // R10: a launched request keeps its address while registers change.
    p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_valid && !bp_ready && cfg_we) |=> $stable(bp_addr));

    // R1: the reset state is idle at the host and backplane.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (!bp_valid && !hst_ready));

endmodule

// File: tb/bpwin_xlate_bench.sv
`timescale 1ns/1ps
module bpwin_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        hst_req = 1'b0;
    logic        hst_we = 1'b0;
    logic [11:0] hst_off = '0;
    logic [1:0]  hst_be = '0;
    logic [15:0] hst_wdata = '0;
    logic        hst_ready;
    logic [15:0] hst_rdata;
    logic        bp_valid;
    logic        bp_we;
    logic [31:0] bp_addr;
    logic [1:0]  bp_be;
    logic [15:0] bp_wdata;
    logic        bp_ready = 1'b0;
    logic        bp_rsp_valid = 1'b0;
    logic        bp_rsp_err = 1'b0;
    logic [15:0] bp_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    // Behavioural register model
    int m_nib = 0, m_mid = 0, m_hi = 0, m_seg = 0;

    always #2.5 clk = ~clk;

    bpwin_xlate u_bpwin_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .hst_req(hst_req), .hst_we(hst_we), .hst_off(hst_off), .hst_be(hst_be),
        .hst_wdata(hst_wdata), .hst_ready(hst_ready), .hst_rdata(hst_rdata),
        .bp_valid(bp_valid), .bp_we(bp_we), .bp_addr(bp_addr), .bp_be(bp_be),
        .bp_wdata(bp_wdata), .bp_ready(bp_ready), .bp_rsp_valid(bp_rsp_valid),
        .bp_rsp_err(bp_rsp_err), .bp_rsp_data(bp_rsp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input logic [7:0] a);
        case (a)
            8'h2E: return m_nib;
            8'h30: return m_mid;
            8'h32: return m_hi;
            8'h34: return m_seg;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        case (a)
            8'h2E: return "R3 nibble readback";
            8'h30, 8'h32: return "R2 byte readback";
            8'h34: return "R4 segment readback";
            default: return "R5 unmapped readback";
        endcase
    endfunction

    function automatic logic [31:0] model_addr(input logic [11:0] off);
        logic [31:0] a;
        a = 32'(m_hi) << 24;
        a = a | (32'(m_mid) << 16);
        a = a | (32'(m_nib) << 12);
        a = a | (32'(m_seg) << 11);
        a = a | 32'(off & 12'h7FF);
        return a;
    endfunction

    // Model update at the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_nib = 0; m_mid = 0; m_hi = 0; m_seg = 0;
        end else if (cfg_we) begin
            case (cfg_addr)
                8'h2E: m_nib = int'(cfg_wdata) % 16;
                8'h30: m_mid = int'(cfg_wdata);
                8'h32: m_hi  = int'(cfg_wdata);
                8'h34: m_seg = int'(cfg_wdata) % 2;
                default: ;
            endcase
        end
    end

    // Per-clock comparison of the readback port against the model
    always @(negedge clk) begin
        if (model_on && !done)
            chk(tag_for(cfg_addr), 32'(cfg_rdata), 32'(model_read(cfg_addr)));
    end

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_look(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cfg_addr = a;
        #0.5;
        chk(tag, 32'(cfg_rdata), 32'(exp));
        @(negedge clk);
    endtask

    // One host access; bench plays the backplane. Called at a negedge.
    task automatic do_access(input string tag, input bit we, input logic [11:0] off,
                             input logic [1:0] be, input logic [15:0] wd,
                             input int rdy_wait, input int rsp_wait,
                             input bit err, input logic [15:0] rsp_d,
                             input bit cc_now, input bit cc_mid,
                             input logic [7:0] cc_a, input logic [7:0] cc_d);
        logic [31:0] exp_addr;
        exp_addr = model_addr(off);
        hst_req = 1'b1; hst_we = we; hst_off = off; hst_be = be; hst_wdata = wd;
        if (cc_now) begin cfg_we = 1'b1; cfg_addr = cc_a; cfg_wdata = cc_d; end
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        chk({tag, " R7 valid"}, 32'(bp_valid), 32'd1);
        chk({tag, " R6/R10 addr"}, bp_addr, exp_addr);
        chk({tag, " R7 we"}, 32'(bp_we), 32'(we));
        chk({tag, " R11 be"}, 32'(bp_be), 32'(be));
        if (we) chk({tag, " R11 wdata"}, 32'(bp_wdata), 32'(wd));
        chk({tag, " R8 ready low"}, 32'(hst_ready), 32'd0);
        for (int i = 0; i < rdy_wait; i++) begin
            if (cc_mid && i == 0) begin cfg_we = 1'b1; cfg_addr = cc_a; cfg_wdata = cc_d; end
            @(posedge clk); @(negedge clk);
            cfg_we = 1'b0;
            chk({tag, " R7 held valid"}, 32'(bp_valid), 32'd1);
            chk({tag, " R10 held addr"}, bp_addr, exp_addr);
            chk({tag, " R8 ready low in stall"}, 32'(hst_ready), 32'd0);
        end
        bp_ready = 1'b1;
        if (!we && rsp_wait == 0) begin
            bp_rsp_valid = 1'b1; bp_rsp_err = err; bp_rsp_data = rsp_d;
        end
        @(posedge clk); @(negedge clk);
        bp_ready = 1'b0; bp_rsp_valid = 1'b0; bp_rsp_err = 1'b0;
        if (!we && rsp_wait > 0) begin
            for (int i = 0; i < rsp_wait; i++) begin
                chk({tag, " R8 read pending"}, 32'(hst_ready), 32'd0);
                chk({tag, " R7 single request"}, 32'(bp_valid), 32'd0);
                @(negedge clk);
            end
            bp_rsp_valid = 1'b1; bp_rsp_err = err; bp_rsp_data = rsp_d;
            @(posedge clk); @(negedge clk);
            bp_rsp_valid = 1'b0; bp_rsp_err = 1'b0;
        end
        chk({tag, " R8 ready pulse"}, 32'(hst_ready), 32'd1);
        if (!we) chk({tag, err ? " R9 error data" : " R9 read data"},
                     32'(hst_rdata), err ? 32'h0000FFFF : 32'(rsp_d));
        hst_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({tag, " R8 ready drops"}, 32'(hst_ready), 32'd0);
        chk({tag, " R7 no second request"}, 32'(bp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 no request in reset", 32'(bp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1'b1;
        chk("R1 idle valid", 32'(bp_valid), 32'd0);
        chk("R1 idle ready", 32'(hst_ready), 32'd0);
        cfg_look(8'h2E, 8'h00, "R1 reset nibble");
        cfg_look(8'h30, 8'h00, "R1 reset mid");
        cfg_look(8'h32, 8'h00, "R1 reset hi");
        cfg_look(8'h34, 8'h00, "R1 reset seg");

        cfg_write(8'h2E, 8'hA7);
        cfg_write(8'h30, 8'h5C);
        cfg_write(8'h32, 8'h18);
        cfg_write(8'h34, 8'h03);
        cfg_write(8'h31, 8'hFF);
        cfg_write(8'h2F, 8'hFF);
        cfg_write(8'h00, 8'h12);
        cfg_look(8'h2E, 8'h07, "R3 upper nibble dropped");
        cfg_look(8'h30, 8'h5C, "R2 mid readback");
        cfg_look(8'h32, 8'h18, "R2 hi readback");
        cfg_look(8'h34, 8'h01, "R4 only bit0 kept");
        cfg_look(8'h31, 8'h00, "R5 unmapped reads zero");
        cfg_look(8'h00, 8'h00, "R5 unmapped reads zero");

        do_access("wr16", 1'b1, 12'h124, 2'b11, 16'hBEEF, 2, 0, 1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 8'h0);
        chk("R6 formed address value", model_addr(12'h124), 32'h185C7924);
        do_access("rd8 off11", 1'b0, 12'h8A6, 2'b01, 16'h0, 0, 3, 1'b0, 16'h1234, 1'b0, 1'b0, 8'h0, 8'h0);
        do_access("rd err", 1'b0, 12'h010, 2'b11, 16'h0, 1, 2, 1'b1, 16'h5555, 1'b0, 1'b0, 8'h0, 8'h0);
        do_access("rd same cyc", 1'b0, 12'h7FE, 2'b11, 16'h0, 0, 0, 1'b0, 16'hC3A5, 1'b0, 1'b0, 8'h0, 8'h0);
        do_access("rd err same", 1'b0, 12'h002, 2'b11, 16'h0, 0, 0, 1'b1, 16'h0000, 1'b0, 1'b0, 8'h0, 8'h0);
        do_access("wide lo", 1'b0, 12'h040, 2'b11, 16'h0, 0, 1, 1'b0, 16'h3210, 1'b0, 1'b0, 8'h0, 8'h0);
        do_access("wide hi", 1'b0, 12'h042, 2'b11, 16'h0, 0, 1, 1'b0, 16'h7654, 1'b0, 1'b0, 8'h0, 8'h0);
        do_access("wr hi byte", 1'b1, 12'h333, 2'b10, 16'hAB00, 0, 0, 1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 8'h0);

        // R10: segment change in the launch cycle
        do_access("cc launch", 1'b1, 12'h100, 2'b11, 16'h1111, 1, 0, 1'b0, 16'h0, 1'b1, 1'b0, 8'h34, 8'h00);
        do_access("after seg", 1'b1, 12'h100, 2'b11, 16'h2222, 0, 0, 1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 8'h0);
        chk("R10 new segment used", model_addr(12'h100), 32'h185C7100);
        // R10: base change while stalled
        do_access("cc stall", 1'b0, 12'h200, 2'b11, 16'h0, 3, 1, 1'b0, 16'h0F0F, 1'b0, 1'b1, 8'h32, 8'hE1);
        do_access("after base", 1'b0, 12'h200, 2'b11, 16'h0, 0, 0, 1'b0, 16'hF0F0, 1'b0, 1'b0, 8'h0, 8'h0);

        // R12: stray response while idle
        bp_rsp_valid = 1'b1; bp_rsp_err = 1'b1; bp_rsp_data = 16'hDEAD;
        @(posedge clk); @(negedge clk);
        bp_rsp_valid = 1'b0; bp_rsp_err = 1'b0;
        chk("R12 stray ignored ready", 32'(hst_ready), 32'd0);
        chk("R12 stray ignored valid", 32'(bp_valid), 32'd0);
        do_access("R12 after stray", 1'b0, 12'h0AA, 2'b11, 16'h0, 0, 2, 1'b0, 16'h4242, 1'b0, 1'b0, 8'h0, 8'h0);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule